// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Control Bank

This block keeps the reset and clock-stop state for up to 64 peripherals in four 32-bit registers. Two registers hold reset lines and two hold clock-stop lines. A simple single-cycle request port writes and reads them. Each register has two addresses. A write to the base address sets every bit that is 1 in the write data. A write to the alias four bytes above clears every bit that is 1 in the write data. In both cases a 0 in the write data leaves the stored bit as it was. Software can therefore change one line without a read-modify-write sequence and without a race against another agent.

The stored bits drive the peripheral-facing outputs directly. A reset bit that is set holds its peripheral in reset. A clock-stop bit that is set turns its clock enable off. The exception is line 14, which works the other way: its clock is enabled when its bit is set. Bit 31 of the first clock-stop register also drives a select that chooses the divide-by-13 rate for a group of UART clocks. After reset every peripheral is held in reset with its clock off.

Top module: `ckrs_ctrl_bank`

## Requirements
- R1: After reset, `periph_rst` is all ones, `periph_clk_en` is all zeros and `uart_slow_sel` is 1. The first clock-stop register reads 0xFFFFBFFF, because bit 14 comes up clear, and every other register reads 0xFFFFFFFF.
- R2: A write to a register base address ORs the write data into that register. Zero data bits leave the stored bits unchanged.
- R3: A write to base+0x4 (the clear alias) clears every register bit whose write-data bit is 1. Zero data bits leave the stored bits unchanged.
- R4: The reset registers are at 0x040 (lines 0 to 31) and 0x050 (lines 32 to 63). The clock-stop registers are at 0x080 (lines 0 to 31) and 0x090 (lines 32 to 63). Line i lives in the register for i/32, at bit i mod 32.
- R5: `periph_rst[i]` equals the stored reset bit of line i. A 1 means the peripheral is held in reset.
- R6: `periph_clk_en[i]` is the inverse of the stored clock-stop bit of line i for every line except line 14. For line 14, `periph_clk_en[14]` equals its stored bit.
- R7: `uart_slow_sel` equals bit 31 of the clock-stop register at 0x080. A 1 selects the divide-by-13 UART rate.
- R8: A read request (`bus_valid`=1, `bus_write`=0) gives `bus_rvalid`=1 on the next cycle. In that cycle `bus_rdata` holds the register's stored value. A read at the base address and a read at the clear alias return the same value. Reads change no state.
- R9: An address that is not one of the eight mapped addresses, including a misaligned one, reads as zero. A write to such an address changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe for one cycle |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 12 | Byte address of the request |
| bus_wdata | input | 32 | Write data; each 1 bit is acted on |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| periph_rst | output | 64 | Reset hold per peripheral line, 1 = held in reset |
| periph_clk_en | output | 64 | Clock enable per peripheral line |
| uart_slow_sel | output | 1 | Selects the divide-by-13 UART clock rate |

## Verification
The set and clear addresses of every register are driven with sparse masks, dense masks and alternating masks. After each write the bench compares all 64 reset and clock-enable outputs with a model. This shows whether untouched bits survive, and whether a set and a clear to the same register are kept apart. Line 14 and line 31 are toggled on their own, so that an inverted polarity or a misplaced divider select is told apart from ordinary clock-stop behaviour. Misaligned, neighbouring and out-of-range addresses are written with all-ones data and then read back. This shows whether the decoder is exact or merely partial.

// File: rtl/ckrs_pkg.sv
package ckrs_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [0:0] {
    KIND_RST  = 1'b0,
    KIND_STOP = 1'b1
  } reg_kind_e;

  // Byte offset of the base address of register r (reset group first, then stop group)
  function automatic int unsigned reg_base(input int unsigned r, input int unsigned banks,
                                           input int unsigned rst_base, input int unsigned stop_base,
                                           input int unsigned stride);
    if (r < banks) return rst_base + r * stride;
    return stop_base + (r - banks) * stride;
  endfunction
endpackage

// File: rtl/ckrs_addr_decode.sv
module ckrs_addr_decode
  import ckrs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANKS     = 2,
  parameter int unsigned NREG      = 2 * BANKS,
  parameter int unsigned RST_BASE  = 32'h040,
  parameter int unsigned STOP_BASE = 32'h080,
  parameter int unsigned STRIDE    = 32'h010,
  parameter int unsigned CLR_OFS   = 32'h004
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   set_sel,
  output logic [NREG-1:0]   clr_sel,
  output logic              hit
);
  for (genvar r = 0; r < NREG; r++) begin : g_dec
    localparam int unsigned BASE = reg_base(r, BANKS, RST_BASE, STOP_BASE, STRIDE);
    assign set_sel[r] = (addr == ADDR_W'(BASE));
    assign clr_sel[r] = (addr == ADDR_W'(BASE + CLR_OFS));
  end

  assign hit = |{set_sel, clr_sel};
endmodule

// File: rtl/ckrs_bank.sv
module ckrs_bank
  import ckrs_pkg::*;
#(
  parameter int unsigned        W         = REG_W,
  parameter logic [W-1:0]       RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic         ld_en;
  logic [W-1:0] q_nxt;

  always_comb begin
    ld_en = set_en | clr_en;
    q_nxt = q;
    if (set_en)      q_nxt = q | wdata;
    else if (clr_en) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RESET_VAL;
    else if (ld_en) q <= q_nxt;
  end
endmodule

// File: rtl/ckrs_ctrl_bank.sv
module ckrs_ctrl_bank
  import ckrs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned LINES      = 64,
  parameter int unsigned RST_BASE   = 32'h040,
  parameter int unsigned STOP_BASE  = 32'h080,
  parameter int unsigned STRIDE     = 32'h010,
  parameter int unsigned CLR_OFS    = 32'h004,
  parameter int unsigned INV_LINE   = 14,
  parameter int unsigned DIV13_LINE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [LINES-1:0]  periph_rst,
  output logic [LINES-1:0]  periph_clk_en,
  output logic              uart_slow_sel
);
  localparam int unsigned BANKS    = LINES / REG_W;
  localparam int unsigned NREG     = 2 * BANKS;
  localparam int unsigned INV_BANK = INV_LINE / REG_W;
  localparam logic [LINES-1:0] INV_MASK = LINES'(1) << INV_LINE;

  logic [NREG-1:0]  set_sel, clr_sel;
  logic             addr_hit;
  logic             wr_req, rd_req;
  logic [REG_W-1:0] q [NREG];
  logic [LINES-1:0] stop_flat;
  logic [REG_W-1:0] rd_mux;
  logic             rvalid_nxt;

  assign wr_req = bus_valid & bus_write;
  assign rd_req = bus_valid & ~bus_write;

  ckrs_addr_decode #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .NREG(NREG), .RST_BASE(RST_BASE),
    .STOP_BASE(STOP_BASE), .STRIDE(STRIDE), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .addr(bus_addr), .set_sel(set_sel), .clr_sel(clr_sel), .hit(addr_hit)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam bit IS_INV_BANK = (r >= BANKS) && ((r - BANKS) == INV_BANK);
    localparam logic [REG_W-1:0] RV =
      IS_INV_BANK ? ~(REG_W'(1) << (INV_LINE % REG_W)) : '1;
    ckrs_bank #(.W(REG_W), .RESET_VAL(RV)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(wr_req & set_sel[r]), .clr_en(wr_req & clr_sel[r]),
      .wdata(bus_wdata), .q(q[r])
    );
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_flat
    assign periph_rst[b*REG_W +: REG_W] = q[b];
    assign stop_flat[b*REG_W +: REG_W]  = q[BANKS + b];
  end

  // Stop bits disable their clock; the inverted line enables on a set bit
  assign periph_clk_en = ~stop_flat ^ INV_MASK;
  assign uart_slow_sel = stop_flat[DIV13_LINE];

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (set_sel[r] | clr_sel[r]) rd_mux = rd_mux | q[r];
    end
  end

  assign rvalid_nxt = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rvalid <= 1'b0;
    else        bus_rvalid <= rvalid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  // R2: bits written to the first reset register's set address are 1 afterwards
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == ADDR_W'(RST_BASE)) |=>
      ((periph_rst[REG_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: bits written to the clear alias are 0 afterwards
  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == ADDR_W'(RST_BASE + CLR_OFS)) |=>
      ((periph_rst[REG_W-1:0] & $past(bus_wdata)) == '0));

  // R6: setting the inverted line's stop bit turns its clock on
  a_r6_inv_line_on: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == ADDR_W'(STOP_BASE + INV_BANK * STRIDE)
     && bus_wdata[INV_LINE % REG_W]) |=> periph_clk_en[INV_LINE]);

  // R8: every read request is answered on the next cycle, and only then
  a_r8_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  a_r8_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  // R9: no mapped write means no output change
  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && addr_hit) |=>
      ($stable(periph_rst) && $stable(periph_clk_en) && $stable(uart_slow_sel)));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/ckrs_ctrl_bank_tb.sv
module ckrs_ctrl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [63:0] periph_rst, periph_clk_en;
  logic        uart_slow_sel;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [63:0] rst_m, stop_m;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ckrs_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .periph_rst(periph_rst), .periph_clk_en(periph_clk_en),
    .uart_slow_sel(uart_slow_sel)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model_wr(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h040: rst_m[31:0]   = rst_m[31:0]   |  d;
      12'h044: rst_m[31:0]   = rst_m[31:0]   & ~d;
      12'h050: rst_m[63:32]  = rst_m[63:32]  |  d;
      12'h054: rst_m[63:32]  = rst_m[63:32]  & ~d;
      12'h080: stop_m[31:0]  = stop_m[31:0]  |  d;
      12'h084: stop_m[31:0]  = stop_m[31:0]  & ~d;
      12'h090: stop_m[63:32] = stop_m[63:32] |  d;
      12'h094: stop_m[63:32] = stop_m[63:32] & ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(logic [11:0] a);
    case (a)
      12'h040, 12'h044: return rst_m[31:0];
      12'h050, 12'h054: return rst_m[63:32];
      12'h080, 12'h084: return stop_m[31:0];
      12'h090, 12'h094: return stop_m[63:32];
      default:          return 32'h0;
    endcase
  endfunction

  function automatic logic [63:0] exp_clk_en();
    return ~stop_m ^ (64'h1 << 14);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_outs(string tag);
    check(tag, "periph_rst", periph_rst, rst_m);
    check(tag, "periph_clk_en", periph_clk_en, exp_clk_en());
    check(tag, "uart_slow_sel", {63'h0, uart_slow_sel}, {63'h0, stop_m[31]});
  endtask

  // Monitor: pops expected read data when the design answers
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected rvalid", 64'h1, 64'h0);
      end else begin
        check(tag_q.pop_front(), "bus_rdata", {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_m  = '1;
    stop_m = ~(64'h1 << 14);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_outs("R1");
    check("R1", "clk_en all off", periph_clk_en, 64'h0);
    rd(12'h040, "R1"); rd(12'h050, "R1"); rd(12'h080, "R1"); rd(12'h090, "R1");

    // R3: clear alias, sparse mask
    wr(12'h044, 32'h0000_00F0); chk_outs("R3");
    rd(12'h040, "R3");
    // R2: set restores a single bit, others untouched
    wr(12'h040, 32'h0000_0010); chk_outs("R2");
    // R5: dense clear on upper reset bank
    wr(12'h054, 32'hFFFF_0000); chk_outs("R5");
    // R4: line 35 lives at bit 3 of 0x050
    wr(12'h050, 32'hFFFF_FFFF);
    wr(12'h054, 32'h0000_0008);
    check("R4", "line 35 released", {63'h0, periph_rst[35]}, 64'h0);
    check("R4", "line 3 held", {63'h0, periph_rst[3]}, 64'h1);
    chk_outs("R4");

    // R6: alternating clear on upper clock-stop bank
    wr(12'h094, 32'hA5A5_5A5A); chk_outs("R6");
    wr(12'h090, 32'h0000_5A00); chk_outs("R6");
    // R6: inverted line 14
    wr(12'h084, 32'h0000_4003);
    check("R6", "line 14 off after clear", {63'h0, periph_clk_en[14]}, 64'h0);
    check("R6", "line 0 on after clear", {63'h0, periph_clk_en[0]}, 64'h1);
    wr(12'h080, 32'h0000_4000);
    check("R6", "line 14 on after set", {63'h0, periph_clk_en[14]}, 64'h1);
    chk_outs("R6");
    // R4: line 46 at bit 14 of 0x090 is normal sense
    wr(12'h094, 32'h0000_4000);
    check("R4", "line 46 normal sense", {63'h0, periph_clk_en[46]}, 64'h1);

    // R7: divide-by-13 select
    wr(12'h084, 32'h8000_0000);
    check("R7", "uart_slow_sel clear", {63'h0, uart_slow_sel}, 64'h0);
    wr(12'h080, 32'h8000_0000);
    check("R7", "uart_slow_sel set", {63'h0, uart_slow_sel}, 64'h1);
    wr(12'h094, 32'h8000_0000);
    check("R7", "upper bit 31 no effect", {63'h0, uart_slow_sel}, 64'h1);

    // R8: aliases read the same, back-to-back reads, reads have no effect
    rd(12'h044, "R8"); rd(12'h054, "R8"); rd(12'h084, "R8"); rd(12'h094, "R8");
    rd(12'h090, "R8");
    @(negedge clk);
    chk_outs("R8");

    // R9: unmapped and misaligned addresses
    wr(12'h048, 32'hFFFF_FFFF); chk_outs("R9");
    wr(12'h042, 32'hFFFF_FFFF); chk_outs("R9");
    wr(12'h098, 32'hFFFF_FFFF); chk_outs("R9");
    wr(12'h0C0, 32'hFFFF_FFFF); chk_outs("R9");
    wr(12'h840, 32'hFFFF_FFFF); chk_outs("R9");
    rd(12'h048, "R9"); rd(12'h081, "R9"); rd(12'h000, "R9"); rd(12'hC80, "R9");

    // R2/R3 final sweep on all registers
    wr(12'h080, 32'h1234_5678); wr(12'h044, 32'h0F0F_0F0F); chk_outs("R2");
    rd(12'h040, "R3"); rd(12'h080, "R2");

    repeat (3) @(negedge clk);
    check("R8", "pending reads", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule